// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

Two agents share one RAM through two independent ports. This block gives each side a doorbell interrupt. The two highest words of the address space serve as mailboxes. The next-to-last word belongs to the left side and the last word belongs to the right side. When one side writes the other side's mailbox word, the owner's interrupt is raised. When the owner later reads that word, its interrupt drops again.

The mailbox words are still ordinary RAM storage, and the message held in them means whatever software decides. This block watches the access controls and does nothing else. The RAM array, the data path and collision arbitration all sit outside it. A port whose busy input is high cannot set or clear a flag. Both flag outputs are registered and active low.

Top module: `mbox_irq`

## Requirements
- R1: While reset is low, and on the first cycle after it, both `left_irq_n` and `right_irq_n` are 1 (deasserted).
- R2: A right-port write to the left mailbox sets the left flag, so `left_irq_n` is 0 after the next rising clock edge. A write is `right_en`=1 and `right_wr`=1 with `right_busy`=0. The left mailbox address is 2**ADDR_W-2, which is 0x1FFE at the default width.
- R3: A left-port read of the left mailbox clears the left flag, so `left_irq_n` is 1 after the next edge. A read is `left_en`=1 and `left_oe`=1 with `left_busy`=0, whatever the value of `left_wr`.
- R4: A left-port write to the right mailbox sets the right flag, so `right_irq_n` is 0 after the next edge. The right mailbox address is 2**ADDR_W-1, which is 0x1FFF at the default width.
- R5: A right-port read of the right mailbox clears the right flag, so `right_irq_n` is 1 after the next edge.
- R6: When the acting port's busy input is 1, its write or read of a mailbox leaves the affected flag unchanged.
- R7: If the same flag is set and cleared in the same cycle, the flag ends up set (output 0).
- R8: Nothing else changes a flag. This covers accesses to other addresses, any access with enable low, a port writing its own mailbox, and a port reading the other side's mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| left_en | input | 1 | Left port access enable |
| left_wr | input | 1 | Left port write strobe |
| left_oe | input | 1 | Left port output enable (read) |
| left_addr | input | ADDR_W | Left port word address |
| left_busy | input | 1 | Left port busy; blocks flag effects of left accesses |
| right_en | input | 1 | Right port access enable |
| right_wr | input | 1 | Right port write strobe |
| right_oe | input | 1 | Right port output enable (read) |
| right_addr | input | ADDR_W | Right port word address |
| right_busy | input | 1 | Right port busy; blocks flag effects of right accesses |
| left_irq_n | output | 1 | Left interrupt flag, active low |
| right_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The bench builds the block with the default 13-bit address and with set-over-clear priority enabled. At that width the mailboxes are 0x1FFE and 0x1FFF. The random address draw is weighted heavily toward the two mailbox words and the word just below them. Because of that weighting, the random cycles often produce a set and a clear of the same flag together, a busy port hitting a mailbox, and near-miss addresses.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

   // Per-port access controls bundled for the decoders.
   typedef struct packed {
      logic en;
      logic wr;
      logic oe;
      logic busy;
   } mbx_ctl_t;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } mbx_side_e;

   // Mailbox word of a side: the two top words of the address space.
   function automatic int unsigned mbx_box_addr(int unsigned aw, mbx_side_e side);
      return (32'd1 << aw) - 32'd2 + {31'd0, side};
   endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned OWN_BOX  = 8190,
   parameter int unsigned PEER_BOX = 8191
) (
   input  mbx_ctl_t          ctl,
   input  logic [ADDR_W-1:0] addr,
   output logic              post_peer,
   output logic              take_own
);
   localparam logic [ADDR_W-1:0] OWN_A  = OWN_BOX[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] PEER_A = PEER_BOX[ADDR_W-1:0];

   logic live;

   always_comb begin
      live      = ctl.en & ~ctl.busy;
      post_peer = live & ctl.wr & (addr == PEER_A);
      take_own  = live & ctl.oe & (addr == OWN_A);
   end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   logic pend_q, pend_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb pend_d = set | (pend_q & ~clr);
      end else begin : g_clr_first
         always_comb pend_d = ~clr & (pend_q | set);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign irq_n = ~pend_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
   import mbox_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              left_en,
   input  logic              left_wr,
   input  logic              left_oe,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic              left_busy,
   input  logic              right_en,
   input  logic              right_wr,
   input  logic              right_oe,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic              right_busy,
   output logic              left_irq_n,
   output logic              right_irq_n
);
   localparam int unsigned NPORT = 2;
   localparam int unsigned BOX_L = mbx_box_addr(ADDR_W, SIDE_LEFT);
   localparam int unsigned BOX_R = mbx_box_addr(ADDR_W, SIDE_RIGHT);

   generate
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_width
         $error("mbox_irq: ADDR_W must lie in 2..30");
      end
   endgenerate

   mbx_ctl_t          ctl    [NPORT];
   logic [ADDR_W-1:0] addr   [NPORT];
   logic [NPORT-1:0]  post, take, irq_n;

   always_comb begin
      ctl[0]  = '{en: left_en,  wr: left_wr,  oe: left_oe,  busy: left_busy};
      ctl[1]  = '{en: right_en, wr: right_wr, oe: right_oe, busy: right_busy};
      addr[0] = left_addr;
      addr[1] = right_addr;
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         mbox_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (p == 0 ? BOX_L : BOX_R),
            .PEER_BOX(p == 0 ? BOX_R : BOX_L)
         ) u_dec (
            .ctl      (ctl[p]),
            .addr     (addr[p]),
            .post_peer(post[p]),
            .take_own (take[p])
         );

         // flag p is raised by the other port, dropped by its owner
         mbox_irq_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (post[NPORT-1-p]),
            .clr  (take[p]),
            .irq_n(irq_n[p])
         );
      end
   endgenerate

   assign left_irq_n  = irq_n[0];
   assign right_irq_n = irq_n[1];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              left_en,
   input logic              left_wr,
   input logic              left_oe,
   input logic [ADDR_W-1:0] left_addr,
   input logic              left_busy,
   input logic              right_en,
   input logic              right_wr,
   input logic              right_oe,
   input logic [ADDR_W-1:0] right_addr,
   input logic              right_busy,
   input logic              left_irq_n,
   input logic              right_irq_n
);
   localparam logic [ADDR_W-1:0] TOP_A = '1;
   localparam logic [ADDR_W-1:0] LBOX  = TOP_A - 1'b1;
   localparam logic [ADDR_W-1:0] RBOX  = TOP_A;

   logic l_set, l_clr, r_set, r_clr, l_try_clr;
   assign l_set     = right_en & right_wr & ~right_busy & (right_addr == LBOX);
   assign l_clr     = left_en  & left_oe  & ~left_busy  & (left_addr  == LBOX);
   assign r_set     = left_en  & left_wr  & ~left_busy  & (left_addr  == RBOX);
   assign r_clr     = right_en & right_oe & ~right_busy & (right_addr == RBOX);
   assign l_try_clr = left_en  & left_oe  & left_busy   & (left_addr  == LBOX);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (left_irq_n && right_irq_n));
   // R2
   left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_set |=> !left_irq_n);
   // R3
   left_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_clr && !l_set) |=> left_irq_n);
   // R4
   right_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_set |=> !right_irq_n);
   // R5
   right_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_clr && !r_set) |=> right_irq_n);
   // R6
   left_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_try_clr && !l_set) |=> $stable(left_irq_n));
   // R8
   left_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_set && !l_clr) |=> $stable(left_irq_n));
   // R8
   right_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_set && !r_clr) |=> $stable(right_irq_n));
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_test.sv
module mbox_irq_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 13;
   localparam logic [AW-1:0] LBOX = 13'h1FFE;
   localparam logic [AW-1:0] RBOX = 13'h1FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_en = 0, l_wr = 0, l_oe = 0, l_busy = 0;
   logic r_en = 0, r_wr = 0, r_oe = 0, r_busy = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic left_irq_n, right_irq_n;

   int checks = 0, fails = 0;
   bit done = 0;
   logic exp_l = 0, exp_r = 0;   // expected pending flags (1 = raised)
   string tag_l, tag_r;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_irq #(.ADDR_W(AW), .SET_WINS(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .left_en(l_en), .left_wr(l_wr), .left_oe(l_oe), .left_addr(l_addr), .left_busy(l_busy),
      .right_en(r_en), .right_wr(r_wr), .right_oe(r_oe), .right_addr(r_addr), .right_busy(r_busy),
      .left_irq_n(left_irq_n), .right_irq_n(right_irq_n)
   );

   function automatic logic f_next(logic f, logic set, logic clr);
      return set | (f & ~clr);
   endfunction

   function automatic string f_tag(logic set, logic clr, logic tried,
                                   string set_tag, string clr_tag);
      if (set && clr) return "R7";
      if (set)        return set_tag;
      if (clr)        return clr_tag;
      if (tried)      return "R6";
      return "R8";
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one access cycle: drive at negedge, edge, compare at next negedge
   task automatic cyc(logic le, logic lw, logic lo, logic [AW-1:0] la, logic lb,
                      logic re, logic rw, logic ro, logic [AW-1:0] ra, logic rb);
      logic sl, cl, sr, cr, tl, tr;
      @(negedge clk);
      l_en = le; l_wr = lw; l_oe = lo; l_addr = la; l_busy = lb;
      r_en = re; r_wr = rw; r_oe = ro; r_addr = ra; r_busy = rb;
      sl = re & rw & ~rb & (ra == LBOX);
      cl = le & lo & ~lb & (la == LBOX);
      sr = le & lw & ~lb & (la == RBOX);
      cr = re & ro & ~rb & (ra == RBOX);
      tl = (re & rw & rb & (ra == LBOX)) | (le & lo & lb & (la == LBOX));
      tr = (le & lw & lb & (la == RBOX)) | (re & ro & rb & (ra == RBOX));
      tag_l = f_tag(sl, cl, tl, "R2", "R3");
      tag_r = f_tag(sr, cr, tr, "R4", "R5");
      exp_l = f_next(exp_l, sl, cl);
      exp_r = f_next(exp_r, sr, cr);
      @(negedge clk);
      check(tag_l, left_irq_n, ~exp_l);
      check(tag_r, right_irq_n, ~exp_r);
   endtask

   task automatic idle();
      cyc(0,0,0,'0,0, 0,0,0,'0,0);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      int unsigned k = $urandom % 8;
      if (k < 3) return LBOX;
      if (k < 6) return RBOX;
      if (k == 6) return LBOX - 1'b1;
      return AW'($urandom);
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", left_irq_n, 1'b1);
      check("R1", right_irq_n, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", left_irq_n, 1'b1);
      check("R1", right_irq_n, 1'b1);

      // R2 right writes left mailbox; R3 left reads it (wr high too)
      cyc(0,0,0,'0,0, 1,1,0,LBOX,0);
      cyc(1,1,1,LBOX,0, 0,0,0,'0,0);
      // R4 left writes right mailbox; R5 right reads it
      cyc(1,1,0,RBOX,0, 0,0,0,'0,0);
      cyc(0,0,0,'0,0, 1,0,1,RBOX,0);
      // R6 busy blocks a set, then a clear
      cyc(0,0,0,'0,0, 1,1,0,LBOX,1);
      cyc(0,0,0,'0,0, 1,1,0,LBOX,0);
      cyc(1,0,1,LBOX,1, 0,0,0,'0,0);
      // R7 simultaneous set and clear of the left flag
      cyc(1,0,1,LBOX,0, 1,1,0,LBOX,0);
      // R8 own-box write, peer-box read, disabled read, neighbour address
      cyc(1,1,0,LBOX,0, 1,0,1,LBOX,0);
      cyc(0,0,1,LBOX,0, 1,1,0,RBOX,0);
      cyc(1,0,1,LBOX-1'b1,0, 1,1,0,LBOX-1'b1,0);
      cyc(1,0,1,LBOX,0, 0,0,0,'0,0);
      idle();

      for (int i = 0; i < 3000; i++) begin
         cyc($urandom%4 != 0, $urandom%2 == 0, $urandom%2 == 0, pick_addr(), $urandom%5 == 0,
             $urandom%4 != 0, $urandom%2 == 0, $urandom%2 == 0, pick_addr(), $urandom%5 == 0);
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule